// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Atomic Byte Access

This block is a 16-bit up-counter that an 8-bit processor bus can read and write. A 3-bit rate code sets how fast it advances. Code 000 holds it still. Code 001 advances it on every clock. Codes 010 to 101 advance it at a divided rate, taken from a free-running 10-bit divider that is cleared by reset.

Full 16-bit values travel over the byte-wide bus in two accesses, and a single 8-bit holding register keeps each transfer atomic. To write, software puts the high byte first into the holding register and then writes the low byte, which loads all 16 bits in one cycle. To read, software reads the low byte first. That read also freezes the high byte in the holding register, so the following high-byte read returns a value that matches the low byte already taken.

Top module: `byte_timer16`

## Requirements
- R1: After a synchronous reset the counter and the holding register are both zero.
- R2: A write with `addrHigh`=1 loads only the holding register. The counter value is unchanged.
- R3: A write with `addrHigh`=0 loads the counter with {holding register, `wrData`} at that clock edge.
- R4: A read with `addrHigh`=0 returns the counter's low byte. At the same edge it copies the counter's high byte into the holding register.
- R5: A read with `addrHigh`=1 returns the holding register, not the live high byte.
- R6: Rate codes 001, 010, 011, 100 and 101 advance the counter by one on every edge, every 8th, every 64th, every 256th and every 1024th edge. For a divide-by-N code the counter advances on the edges k = N-1, 2N-1, and so on, where k counts edges from 0 at the first edge after reset is released.
- R7: Code 000 holds the counter at its value.
- R8: Codes 110 and 111 hold the counter like code 000.
- R9: The counter wraps from 0xFFFF to 0x0000.
- R10: After a 16-bit preset, counting continues upward from the written value on the next rate tick.
- R11: When a low-byte write and a rate tick fall on the same edge, the written value is loaded and the tick is dropped.
- R12: `rdData` is zero whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addrHigh | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte (combinational) |
| clkSel | input | 3 | Rate code |

## Verification
If the holding register picks up a byte on the wrong access, the error stays hidden until the next high-byte read or low-byte write. It then shows at `rdData` or in the counter value on the following read. A fault in the divider tap appears only after a full divide period, so each divided rate is run for more than one period before the count is compared with the edge-based expectation. A collision fault, where the written value is loaded plus one, becomes visible on the next 16-bit read. Reading the high byte after the live count has moved past it separates the buffered value from the live one.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int NUM_RATES = 5;

  // log2 of the divide ratio for rate codes 1..NUM_RATES
  function automatic int rateShift(input int idx);
    case (idx)
      0: return 0;
      1: return 3;
      2: return 6;
      3: return 8;
      default: return 10;
    endcase
  endfunction

  typedef struct packed {
    logic loadTemp;
    logic loadCount;
    logic rdLow;
    logic rdHigh;
    logic tick;
  } tmrStrobe_t;
endpackage

// File: rtl/timer16_ctrl.sv
module timer16_ctrl
  import timer16_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addrHigh,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [SEL_W-1:0] clkSel,
  output tmrStrobe_t       strb
);
  logic [DIV_W-1:0]     divCnt;
  logic [NUM_RATES-1:0] tapTick;
  logic                 rateTick;

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else     divCnt <= divCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    localparam int SH = rateShift(g);
    if (SH == 0) begin : g_full
      assign tapTick[g] = 1'b1;
    end else begin : g_div
      assign tapTick[g] = &divCnt[SH-1:0];
    end
  end

  always_comb begin
    rateTick = 1'b0;
    for (int i = 0; i < NUM_RATES; i++)
      if (clkSel == SEL_W'(i + 1)) rateTick = tapTick[i];
  end

  always_comb begin
    strb.loadTemp  = wrEn & addrHigh;
    strb.loadCount = wrEn & ~addrHigh;
    strb.rdLow     = rdEn & ~addrHigh;
    strb.rdHigh    = rdEn & addrHigh;
    // a bus write of the full value wins over a rate tick
    strb.tick      = rateTick & ~strb.loadCount;
  end
endmodule

// File: rtl/timer16_dp.sv
module timer16_dp
  import timer16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  tmrStrobe_t          strb,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  output logic [2*BYTE_W-1:0] cntVal
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] tempByte;

  always_ff @(posedge clk) begin
    if (rst)                tempByte <= '0;
    else if (strb.loadTemp) tempByte <= wrData;
    else if (strb.rdLow)    tempByte <= cntVal[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst)                 cntVal <= '0;
    else if (strb.loadCount) cntVal <= {tempByte, wrData};
    else if (strb.tick)      cntVal <= cntVal + 1'b1;
  end

  always_comb begin
    if (strb.rdHigh)     rdData = tempByte;
    else if (strb.rdLow) rdData = cntVal[BYTE_W-1:0];
    else                 rdData = '0;
  end
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import timer16_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrHigh,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [SEL_W-1:0]  clkSel
);
  tmrStrobe_t            strb;
  logic [2*BYTE_W-1:0]   cntVal;

  timer16_ctrl #(.SEL_W(SEL_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rst(rst), .addrHigh(addrHigh), .wrEn(wrEn),
    .rdEn(rdEn), .clkSel(clkSel), .strb(strb)
  );

  timer16_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .rdData(rdData), .cntVal(cntVal)
  );
endmodule

// File: rtl/timer16_checker.sv
module timer16_checker #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                addrHigh,
  input logic                wrEn,
  input logic                rdEn,
  input logic [BYTE_W-1:0]   wrData,
  input logic [BYTE_W-1:0]   rdData,
  input logic [SEL_W-1:0]    clkSel,
  input logic [2*BYTE_W-1:0] cntVal
);
  logic lowWrite;
  assign lowWrite = wrEn & ~addrHigh;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> cntVal == '0);

  assert_high_write_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addrHigh && clkSel == '0) |=> $stable(cntVal));

  assert_low_write_loads_R3: assert property (@(posedge clk) disable iff (rst)
    lowWrite |=> cntVal[BYTE_W-1:0] == $past(wrData));

  assert_undivided_step_R6: assert property (@(posedge clk) disable iff (rst)
    (clkSel == SEL_W'(1) && !lowWrite) |=> cntVal == (2*BYTE_W)'($past(cntVal) + 1'b1));

  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (clkSel == '0 && !lowWrite) |=> $stable(cntVal));

  assert_reserved_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (clkSel[SEL_W-1:SEL_W-2] == 2'b11 && !lowWrite) |=> $stable(cntVal));

  assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> rdData == '0);
endmodule

bind byte_timer16 timer16_checker #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) i_chk (
  .clk(clk), .rst(rst), .addrHigh(addrHigh), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .clkSel(clkSel), .cntVal(cntVal)
);

// File: tb/test_byte_timer16.sv
module test_byte_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addrHigh = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [2:0] clkSel = '0;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;

  always #5 clk = ~clk;

  byte_timer16 i_byte_timer16 (
    .clk(clk), .rst(rst), .addrHigh(addrHigh), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .clkSel(clkSel)
  );

  // edges since reset release; index of the coming edge when read at negedge
  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  // vector: addrHigh, wr, rd, data[7:0], expected rdData[7:0]
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h00},  // R1 low byte after reset
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h00},  // R1 holding byte after reset
    {1'b1, 1'b1, 1'b0, 8'h12, 8'h00},  // write high
    {1'b0, 1'b1, 1'b0, 8'h34, 8'h00},  // R3 commit 0x1234
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h34},  // R4
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h12},  // R5
    {1'b1, 1'b1, 1'b0, 8'hAB, 8'h00},  // R2 high write only
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h34},  // R2 count unchanged
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h12},  // R4 temp refreshed
    {1'b1, 1'b1, 1'b0, 8'h56, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h78, 8'h00},  // R3 commit 0x5678
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h56},  // R5 holding byte
    {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00},  // R12 idle
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h78}   // R4
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit tickExp(input logic [2:0] sel, input int e);
    case (sel)
      3'd1: return 1'b1;
      3'd2: return (e % 8) == 7;
      3'd3: return (e % 64) == 63;
      3'd4: return (e % 256) == 255;
      3'd5: return (e % 1024) == 1023;
      default: return 1'b0;
    endcase
  endfunction

  task automatic writeCount(input logic [15:0] v);
    addrHigh = 1'b1; wrEn = 1'b1; wrData = v[15:8];
    @(negedge clk);
    addrHigh = 1'b0; wrData = v[7:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCount(output logic [15:0] v);
    addrHigh = 1'b0; rdEn = 1'b1;
    #1 v[7:0] = rdData;
    @(negedge clk);
    addrHigh = 1'b1;
    #1 v[15:8] = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic runSel(input logic [2:0] sel, input int n, inout logic [15:0] exp);
    clkSel = sel;
    for (int i = 0; i < n; i++) begin
      if (tickExp(sel, edges)) exp = exp + 16'd1;
      @(negedge clk);
    end
    clkSel = 3'd0;
  endtask

  initial begin : watchdog
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] got, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      {addrHigh, wrEn, rdEn, wrData} = VEC[v][18:8];
      #1 chk($sformatf("R2/R3/R4/R5/R12 vector %0d", v), {8'h00, rdData}, {8'h00, VEC[v][7:0]});
      @(negedge clk);
    end
    wrEn = 1'b0; rdEn = 1'b0;

    // R9 wrap and R10 resume after preset
    writeCount(16'hFFFE);
    exp = 16'hFFFE;
    runSel(3'd1, 3, exp);
    readCount(got);
    chk("R9 wrap", got, 16'h0001);
    chk("R10 resume from preset", got, exp);

    // R7 stop holds
    runSel(3'd0, 10, exp);
    readCount(got);
    chk("R7 stop", got, 16'h0001);

    // R8 reserved codes hold
    runSel(3'd6, 30, exp);
    runSel(3'd7, 30, exp);
    readCount(got);
    chk("R8 reserved", got, 16'h0001);

    // R6 divided rates
    writeCount(16'h0000); exp = 16'h0000;
    runSel(3'd2, 70, exp);
    readCount(got);
    chk("R6 divide 8", got, exp);
    writeCount(16'h0000); exp = 16'h0000;
    runSel(3'd3, 300, exp);
    readCount(got);
    chk("R6 divide 64", got, exp);
    writeCount(16'h0000); exp = 16'h0000;
    runSel(3'd4, 600, exp);
    readCount(got);
    chk("R6 divide 256", got, exp);
    writeCount(16'h0000); exp = 16'h0000;
    runSel(3'd5, 2100, exp);
    readCount(got);
    chk("R6 divide 1024", got, exp);
    chk("R6 divide 1024 advanced", {15'd0, exp >= 16'd2}, 16'd1);

    // R5 holding byte differs from live high byte
    writeCount(16'h00FE);
    addrHigh = 1'b0; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    exp = 16'h00FE;
    runSel(3'd1, 4, exp);
    addrHigh = 1'b1; rdEn = 1'b1;
    #1 chk("R5 buffered high byte", {8'h00, rdData}, 16'h0000);
    @(negedge clk);
    addrHigh = 1'b0;
    #1 chk("R4 live low byte", {8'h00, rdData}, 16'h0002);
    @(negedge clk);
    rdEn = 1'b0;

    // R11 write beats a tick on the same edge
    addrHigh = 1'b1; wrEn = 1'b1; wrData = 8'h40;
    @(negedge clk);
    addrHigh = 1'b0; wrData = 8'h10; clkSel = 3'd1;
    @(negedge clk);
    wrEn = 1'b0; clkSel = 3'd0;
    readCount(got);
    chk("R11 write wins over tick", got, 16'h4010);

    // R1 reset mid-run clears counter and holding byte
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    addrHigh = 1'b1; rdEn = 1'b1;
    #1 chk("R1 holding byte cleared", {8'h00, rdData}, 16'h0000);
    @(negedge clk);
    rdEn = 1'b0;
    readCount(got);
    chk("R1 counter cleared", got, 16'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule